// File: doc/BRIEF.md
# TDM Connection Memory Switch

This block holds the per-slot routing table of a time-slot switch on a TDM bus. The bus has 8 streams of 32 channels each, so there are 256 output slots. Each slot owns one 12-bit entry. A host fills the entries through a byte-wide write port in two steps. It first writes the low byte, which waits in a holding register. It then writes the high part, and only that second write stores the whole entry.

A frame timebase presents the index of each output slot in turn. One clock later the block reports what that slot should carry. In connection mode this is a 9-bit read address into the switch's data memory. Several slots may name the same source, which gives broadcast. In message mode it is a constant byte taken straight from the entry. In both modes the block also gives a direction flag, which decides which line of the paired input/output channel drives.

The data memory, the serial shifters and the pad drivers sit outside this block.

Top module: `conn_map_top`

## Requirements
- R1: While reset is active and after it is released, all outputs read zero and every entry reads back as 12'h000.
- R2: A low-byte write (hostWrEn=1, hostHigh=0) changes no stored entry. It only loads the holding register.
- R3: A high-part write (hostWrEn=1, hostHigh=1) stores {hostWrData[3:0], held low byte} at hostAddr. hostRdEntry returns the full stored entry, including reserved bit 11, from the next cycle on. hostWrData[7:4] is ignored.
- R4: The entry layout is: low byte in bits [7:0], source address MSB in bit 8, mode in bit 9, direction in bit 10. When bit 9 is 0 (connection mode), a lookup gives outSrcAddr = entry[8:0], outMsgByte = 0 and outMsgMode = 0.
- R5: When bit 9 is 1 (message mode), a lookup gives outMsgByte = entry[7:0], outMsgMode = 1 and outSrcAddr = 0. Bit 8 has no effect.
- R6: outDirOut equals entry bit 10. A value of 1 means the slot's output line drives and its input line receives; 0 swaps the two.
- R7: Any number of slots may hold the same source address, and each of them reports that address.
- R8: When a high-part write and a lookup hit the same slot in the same cycle, the lookup reports the old entry. Later lookups report the new one.
- R9: A high-part write with no low-byte write since the previous commit uses the last held low byte.
- R10: outValid equals slotValid delayed by one cycle. While outValid is 0, the other lookup outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostHigh | input | 1 | Write selector: 0 = low byte, 1 = high part |
| hostAddr | input | 8 | Slot index for writes, {stream, channel} |
| hostWrData | input | 8 | Write data |
| hostRdAddr | input | 8 | Slot index for readback |
| hostRdEntry | output | 12 | Stored entry at hostRdAddr |
| slotValid | input | 1 | The timebase presents a slot this cycle |
| slotIdx | input | 8 | Current output slot, {stream, channel} |
| outValid | output | 1 | Lookup result valid |
| outMsgMode | output | 1 | 1 = message mode result |
| outSrcAddr | output | 9 | Data-memory read address (connection mode) |
| outMsgByte | output | 8 | Constant byte (message mode) |
| outDirOut | output | 1 | Direction flag of the slot |

## Verification
The hardest case to reach is a commit and a timebase lookup landing on the same slot in one cycle. The bench reaches it by arming the high-part write and the lookup for the same index on the same clock edge. It then checks that the lookup shows the old entry while the readback port already shows the new one. A second hard case is a high write that reuses a stale held byte. The bench reaches it by issuing two back-to-back high writes after a single low write.

// File: rtl/conn_map_pkg.sv
package conn_map_pkg;
  localparam int ENTRY_W   = 12;
  localparam int LOW_W     = 8;
  localparam int HIGH_W    = ENTRY_W - LOW_W;
  localparam int SRC_W     = LOW_W + 1;
  localparam int MODE_BIT  = 9;
  localparam int DIR_BIT   = 10;

  typedef struct packed {
    logic latchLow;
    logic commit;
    logic lookup;
  } ctrlStrobes_t;
endpackage

// File: rtl/conn_map_ctrl.sv
module conn_map_ctrl
  import conn_map_pkg::*;
(
  input  logic         hostWrEn,
  input  logic         hostHigh,
  input  logic         slotValid,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.latchLow = hostWrEn & ~hostHigh;
    strobes.commit   = hostWrEn &  hostHigh;
    strobes.lookup   = slotValid;
  end
endmodule

// File: rtl/conn_map_dp.sv
module conn_map_dp
  import conn_map_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CHANS   = 32,
  localparam int SLOTS      = NUM_STREAMS * NUM_CHANS,
  localparam int IDX_W      = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   hostAddr,
  input  logic [LOW_W-1:0]   hostWrData,
  input  logic [IDX_W-1:0]   hostRdAddr,
  output logic [ENTRY_W-1:0] hostRdEntry,
  input  logic [IDX_W-1:0]   slotIdx,
  output logic               outValid,
  output logic               outMsgMode,
  output logic [SRC_W-1:0]   outSrcAddr,
  output logic [LOW_W-1:0]   outMsgByte,
  output logic               outDirOut
);
  logic [ENTRY_W-1:0] mem [SLOTS];
  logic [LOW_W-1:0]   holdLow;
  logic [ENTRY_W-1:0] curEntry;
  logic               curMsg;

  assign curEntry    = mem[slotIdx];
  assign curMsg      = curEntry[MODE_BIT];
  assign hostRdEntry = mem[hostRdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLow <= '0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      if (strobes.latchLow) holdLow <= hostWrData;
      if (strobes.commit)
        mem[hostAddr] <= {hostWrData[HIGH_W-1:0], holdLow};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outMsgMode <= 1'b0;
      outSrcAddr <= '0;
      outMsgByte <= '0;
      outDirOut  <= 1'b0;
    end else begin
      outValid <= strobes.lookup;
      if (strobes.lookup) begin
        outMsgMode <= curMsg;
        outSrcAddr <= curMsg ? '0 : curEntry[SRC_W-1:0];
        outMsgByte <= curMsg ? curEntry[LOW_W-1:0] : '0;
        outDirOut  <= curEntry[DIR_BIT];
      end
    end
  end
endmodule

// File: rtl/conn_map_top.sv
module conn_map_top
  import conn_map_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CHANS   = 32,
  localparam int IDX_W      = $clog2(NUM_STREAMS * NUM_CHANS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostHigh,
  input  logic [IDX_W-1:0]   hostAddr,
  input  logic [LOW_W-1:0]   hostWrData,
  input  logic [IDX_W-1:0]   hostRdAddr,
  output logic [ENTRY_W-1:0] hostRdEntry,
  input  logic               slotValid,
  input  logic [IDX_W-1:0]   slotIdx,
  output logic               outValid,
  output logic               outMsgMode,
  output logic [SRC_W-1:0]   outSrcAddr,
  output logic [LOW_W-1:0]   outMsgByte,
  output logic               outDirOut
);
  ctrlStrobes_t strobes;

  conn_map_ctrl ctrl_i (
    .hostWrEn (hostWrEn),
    .hostHigh (hostHigh),
    .slotValid(slotValid),
    .strobes  (strobes)
  );

  conn_map_dp #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdAddr (hostRdAddr),
    .hostRdEntry(hostRdEntry),
    .slotIdx    (slotIdx),
    .outValid   (outValid),
    .outMsgMode (outMsgMode),
    .outSrcAddr (outSrcAddr),
    .outMsgByte (outMsgByte),
    .outDirOut  (outDirOut)
  );
endmodule

// File: rtl/conn_map_chk.sv
module conn_map_chk
  import conn_map_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWrEn,
  input logic               hostHigh,
  input logic [IDX_W-1:0]   hostAddr,
  input logic [LOW_W-1:0]   hostWrData,
  input logic [IDX_W-1:0]   hostRdAddr,
  input logic [ENTRY_W-1:0] hostRdEntry,
  input logic               slotValid,
  input logic               outValid,
  input logic               outMsgMode,
  input logic [SRC_W-1:0]   outSrcAddr,
  input logic [LOW_W-1:0]   outMsgByte
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(slotValid));

  a_r5_msg_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMsgMode) |-> outSrcAddr == '0);

  a_r4_conn_no_byte: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outMsgMode) |-> outMsgByte == '0);

  a_r2_only_high_commits: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!(hostWrEn && hostHigh)) && $stable(hostRdAddr)) |-> $stable(hostRdEntry));

  a_r3_commit_visible: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostHigh && hostRdAddr == hostAddr) |=>
      hostRdEntry[ENTRY_W-1:LOW_W] == $past(hostWrData[HIGH_W-1:0]));

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!slotValid) |=> $stable(outSrcAddr) && $stable(outMsgByte));
endmodule

bind conn_map_top conn_map_chk #(.IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostHigh   (hostHigh),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .hostRdAddr (hostRdAddr),
  .hostRdEntry(hostRdEntry),
  .slotValid  (slotValid),
  .outValid   (outValid),
  .outMsgMode (outMsgMode),
  .outSrcAddr (outSrcAddr),
  .outMsgByte (outMsgByte)
);

// File: tb/conn_map_top_tb_top.sv
module conn_map_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostHigh = 1'b0;
  logic [7:0]  hostAddr = '0, hostWrData = '0, hostRdAddr = '0;
  logic [11:0] hostRdEntry;
  logic        slotValid = 1'b0;
  logic [7:0]  slotIdx = '0;
  logic        outValid, outMsgMode, outDirOut;
  logic [8:0]  outSrcAddr;
  logic [7:0]  outMsgByte;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  conn_map_top dut_i (.*);

  // {slot, low byte, high nibble}
  localparam logic [19:0] VEC [8] = '{
    {8'h01, 8'h2A, 4'b0101}, {8'h1D, 8'h77, 4'b0000},
    {8'h20, 8'hC3, 4'b0011}, {8'hFF, 8'h5E, 4'b1110},
    {8'h80, 8'hFF, 4'b1001}, {8'h00, 8'h00, 4'b0100},
    {8'h47, 8'h81, 4'b0111}, {8'h9C, 8'h10, 4'b0001}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic high, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostHigh = high; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic look(logic [7:0] idx);
    @(negedge clk);
    slotValid = 1'b1; slotIdx = idx;
    @(negedge clk);
    slotValid = 1'b0;
  endtask

  task automatic expectLook(string req, logic [11:0] e);
    chk(req, outValid, 1);
    chk(req, outMsgMode, e[9]);
    chk(req, outSrcAddr, e[9] ? 9'h0 : e[8:0]);
    chk(req, outMsgByte, e[9] ? e[7:0] : 8'h0);
    chk(req, outDirOut, e[10]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outValid", outValid, 0);
    chk("R1 outSrcAddr", outSrcAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      hostRdAddr = VEC[i][19:12];
      #0 chk("R1 entry", hostRdEntry, 0);
    end
    chk("R1 outDirOut", outDirOut, 0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [11:0] e;
      e = {VEC[i][3:0], VEC[i][11:4]};
      hostRdAddr = VEC[i][19:12];
      wr(1'b0, VEC[i][19:12], VEC[i][11:4]);
      wr(1'b1, VEC[i][19:12], {4'hA, VEC[i][3:0]});
      chk("R3 readback", hostRdEntry, e);
      look(VEC[i][19:12]);
      expectLook(e[9] ? "R5 R6 msg" : "R4 R6 conn", e);
    end

    // R2: low write alone does not change stored entry
    hostRdAddr = 8'h01;
    wr(1'b0, 8'h01, 8'hEE);
    chk("R2 no commit", hostRdEntry, 12'h52A);
    look(8'h01);
    expectLook("R2 lookup unchanged", 12'h52A);

    // R9: second high write reuses held byte 8'hEE
    wr(1'b1, 8'h01, 8'h00);
    chk("R9 first", hostRdEntry, 12'h0EE);
    hostRdAddr = 8'h33;
    wr(1'b1, 8'h33, 8'h05);
    chk("R9 reuse held", hostRdEntry, 12'h5EE);

    // R7 broadcast: three slots same source 9'h1B4
    for (int s = 0; s < 3; s++) begin
      wr(1'b0, 8'h60 + 8'(s), 8'hB4);
      wr(1'b1, 8'h60 + 8'(s), 8'h01);
    end
    for (int s = 0; s < 3; s++) begin
      look(8'h60 + 8'(s));
      chk("R7 broadcast", outSrcAddr, 9'h1B4);
    end

    // R8 collision on slot 0x61 (old = 0x1B4 conn)
    wr(1'b0, 8'h61, 8'h99);
    hostRdAddr = 8'h61;
    @(negedge clk);
    hostWrEn = 1'b1; hostHigh = 1'b1; hostAddr = 8'h61; hostWrData = 8'h06;
    slotValid = 1'b1; slotIdx = 8'h61;
    @(negedge clk);
    hostWrEn = 1'b0; slotValid = 1'b0;
    expectLook("R8 old entry", 12'h1B4);
    chk("R8 new stored", hostRdEntry, 12'h699);
    look(8'h61);
    expectLook("R8 new lookup", 12'h699);

    // R10: outputs hold while idle
    @(negedge clk);
    chk("R10 valid low", outValid, 0);
    chk("R10 hold byte", outMsgByte, 8'h99);
    chk("R10 hold mode", outMsgMode, 1);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule